// File: doc/BRIEF.md
# NAND Command Phase Decoder

This block turns a requested NAND operation into the control word that a flash sequencer needs before it starts driving pins. For each request it decides which phases the sequencer runs: a first command byte, address cycles, a second command byte and a data transfer. It also sets the transfer direction, whether data moves 16 bits wide, whether large-page (2048-byte) framing is used, and how many address cycles are sent. It also builds a 16-bit command code word that carries the second opcode in its upper byte and the first opcode in its lower byte.

A request is presented with `op_valid` together with an operation code, the device page mode, the bus width and the two address-cycle counts: one for read/write and one for erase. The decoded word appears on registered outputs after a fixed latency of `LAT` clock cycles, marked by `out_valid`. It then holds until the next request arrives. Some operations force 8-bit transfers or small-page framing whatever the device configuration is, and each operation enables its own subset of phases.

Top module: `nand_phase_decoder`

## Requirements
- R1: While reset (`rst_n` low) is applied and until the first request leaves the pipeline, `out_valid` and every control output and `cmd_word` are zero.
- R2: A request accepted on a rising edge with `op_valid` high appears with `out_valid` high exactly `LAT` edges later. When `out_valid` is low, all control outputs and `cmd_word` keep their previous values, whatever `op_code` and the other inputs do while `op_valid` is low.
- R3: Erase (code 5) enables first command, address and second command, with no data phase. It uses the erase count `er_cnt` and gives `cmd_word` 0xD060.
- R4: Read (code 0), read-spare (code 1) and random-out (code 2) enable first command, address and data, with read direction and no second command. They use `rw_cnt` and set `wide_data` equal to `bus_16`. `cmd_word` depends on page mode. With `large_page`=1 it is 0x3000, 0x3000 and 0xE005 for the three codes. With `large_page`=0 it is 0x0000, 0x0050 and 0x0005.
- R5: Program (code 3) enables first command, address, second command and data, with write direction (`write_dir`=1). It uses `rw_cnt`, sets `wide_data` equal to `bus_16` and gives `cmd_word` 0x1080.
- R6: Serial data input (code 4) enables only the first command. Its address count is zero and `cmd_word` is 0x0080.
- R7: Read-ID (code 6) enables first command, address and data, with read direction. It uses exactly one address cycle, forces `wide_data` to 0 and `big_page` to 0, and gives `cmd_word` 0x0090.
- R8: Status (code 7) and reset (code 8) enable only the first command, with a zero address count. They force `big_page` to 0 and give `cmd_word` 0x0070 and 0x00FF respectively.
- R9: For every code other than 6, 7 and 8, `big_page` equals the `large_page` input of the request.
- R10: Any code from 9 to 15 gives the default word: first command and address enabled, no second command, no data, read direction, zero address count and `cmd_word` 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Request strobe |
| op_code | input | 4 | Operation code (see requirements) |
| large_page | input | 1 | Device uses 2048-byte pages |
| bus_16 | input | 1 | Device data bus is 16 bits wide |
| rw_cnt | input | CYC_W | Address cycles for read/program |
| er_cnt | input | CYC_W | Address cycles for erase |
| out_valid | output | 1 | Decoded word updated this cycle |
| cmd1_en | output | 1 | Issue first command byte |
| addr_en | output | 1 | Issue address cycles |
| cmd2_en | output | 1 | Issue second command byte |
| data_en | output | 1 | Data phase present |
| write_dir | output | 1 | Data phase writes to the device |
| wide_data | output | 1 | Data phase is 16 bits wide |
| big_page | output | 1 | Large-page framing selected |
| addr_cnt | output | CYC_W | Number of address cycles |
| cmd_word | output | 16 | {second opcode, first opcode} |

## Verification
The hardest behaviour to observe is the hold rule. The outputs only prove that they ignore idle inputs if those inputs actually change while `op_valid` is low. The stimulus therefore scrambles `op_code`, the page mode, the width and both counts on every idle cycle. It also mixes back-to-back requests with gapped ones, so the pipeline sees both streaming and isolated loads. The forced-off cases (read-ID, status and reset) are driven with `large_page` and `bus_16` both set, because otherwise forcing and passing through look the same.

// File: rtl/nand_phase_pkg.sv
package nand_phase_pkg;

   localparam int OP_W   = 4;
   localparam int FLAG_W = 7;
   localparam int CODE_W = 16;

   typedef enum logic [OP_W-1:0] {
      OP_READ     = 4'd0,
      OP_READ_OOB = 4'd1,
      OP_RND_OUT  = 4'd2,
      OP_PROG     = 4'd3,
      OP_SEQ_IN   = 4'd4,
      OP_ERASE    = 4'd5,
      OP_READ_ID  = 4'd6,
      OP_STATUS   = 4'd7,
      OP_RESET    = 4'd8
   } nand_op_e;

   // Standard NAND device opcode bytes
   localparam logic [7:0] B_READ0     = 8'h00;
   localparam logic [7:0] B_READ_ST   = 8'h30;
   localparam logic [7:0] B_SPARE     = 8'h50;
   localparam logic [7:0] B_RND       = 8'h05;
   localparam logic [7:0] B_RND_ST    = 8'hE0;
   localparam logic [7:0] B_SEQ_IN    = 8'h80;
   localparam logic [7:0] B_PROG      = 8'h10;
   localparam logic [7:0] B_ERASE1    = 8'h60;
   localparam logic [7:0] B_ERASE2    = 8'hD0;
   localparam logic [7:0] B_ID        = 8'h90;
   localparam logic [7:0] B_STATUS    = 8'h70;
   localparam logic [7:0] B_RESET     = 8'hFF;
   localparam logic [7:0] B_NONE      = 8'h00;

endpackage

// File: rtl/nand_phase_map.sv
module nand_phase_map
   import nand_phase_pkg::*;
#(
   parameter int CYC_W = 3
) (
   input  logic [OP_W-1:0]  op,
   input  logic             large_page,
   input  logic             bus_16,
   input  logic [CYC_W-1:0] rw_cnt,
   input  logic [CYC_W-1:0] er_cnt,
   output logic             cmd1,
   output logic             addr,
   output logic             cmd2,
   output logic             data,
   output logic             wdir,
   output logic             wide,
   output logic             big,
   output logic [CYC_W-1:0] cnt
);

   localparam logic [CYC_W-1:0] ONE_CYC = CYC_W'(1);

   always_comb begin
      cmd1 = 1'b1;
      addr = 1'b1;
      cmd2 = 1'b0;
      data = 1'b0;
      wdir = 1'b0;
      wide = 1'b0;
      big  = large_page;
      cnt  = '0;
      case (op)
         OP_ERASE: begin
            cmd2 = 1'b1;
            cnt  = er_cnt;
         end
         OP_READ, OP_READ_OOB, OP_RND_OUT: begin
            data = 1'b1;
            wide = bus_16;
            cnt  = rw_cnt;
         end
         OP_PROG: begin
            cmd2 = 1'b1;
            data = 1'b1;
            wdir = 1'b1;
            wide = bus_16;
            cnt  = rw_cnt;
         end
         OP_SEQ_IN: begin
            addr = 1'b0;
         end
         OP_READ_ID: begin
            big  = 1'b0;
            data = 1'b1;
            cnt  = ONE_CYC;
         end
         OP_STATUS, OP_RESET: begin
            big  = 1'b0;
            addr = 1'b0;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/nand_opcode_pair.sv
module nand_opcode_pair
   import nand_phase_pkg::*;
(
   input  logic [OP_W-1:0]   op,
   input  logic              large_page,
   output logic [CODE_W-1:0] word
);

   logic [7:0] first_b;
   logic [7:0] second_b;

   always_comb begin
      first_b  = B_NONE;
      second_b = B_NONE;
      case (op)
         OP_READ: begin
            first_b  = B_READ0;
            second_b = large_page ? B_READ_ST : B_NONE;
         end
         OP_READ_OOB: begin
            first_b  = large_page ? B_READ0 : B_SPARE;
            second_b = large_page ? B_READ_ST : B_NONE;
         end
         OP_RND_OUT: begin
            first_b  = B_RND;
            second_b = large_page ? B_RND_ST : B_NONE;
         end
         OP_PROG: begin
            first_b  = B_SEQ_IN;
            second_b = B_PROG;
         end
         OP_SEQ_IN:  first_b = B_SEQ_IN;
         OP_ERASE: begin
            first_b  = B_ERASE1;
            second_b = B_ERASE2;
         end
         OP_READ_ID: first_b = B_ID;
         OP_STATUS:  first_b = B_STATUS;
         OP_RESET:   first_b = B_RESET;
         default: ;
      endcase
   end

   assign word = {second_b, first_b};

endmodule

// File: rtl/nand_phase_stage.sv
module nand_phase_stage #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_vld,
   input  logic [W-1:0] in_dat,
   output logic         out_vld,
   output logic [W-1:0] out_dat
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_dat <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) out_dat <= in_dat;
      end
   end

endmodule

// File: rtl/nand_phase_decoder.sv
module nand_phase_decoder
   import nand_phase_pkg::*;
#(
   parameter int CYC_W = 3,
   parameter int LAT   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [OP_W-1:0]   op_code,
   input  logic              large_page,
   input  logic              bus_16,
   input  logic [CYC_W-1:0]  rw_cnt,
   input  logic [CYC_W-1:0]  er_cnt,
   output logic              out_valid,
   output logic              cmd1_en,
   output logic              addr_en,
   output logic              cmd2_en,
   output logic              data_en,
   output logic              write_dir,
   output logic              wide_data,
   output logic              big_page,
   output logic [CYC_W-1:0]  addr_cnt,
   output logic [CODE_W-1:0] cmd_word
);

   localparam int W = FLAG_W + CYC_W + CODE_W;

   if (CYC_W < 1 || CYC_W > 8) begin : g_bad_cyc
      $error("CYC_W must lie in 1..8");
   end
   if (LAT < 1 || LAT > 8) begin : g_bad_lat
      $error("LAT must lie in 1..8");
   end

   logic             f_cmd1, f_addr, f_cmd2, f_data, f_wdir, f_wide, f_big;
   logic [CYC_W-1:0] f_cnt;
   logic [CODE_W-1:0] f_word;

   nand_phase_map #(.CYC_W(CYC_W)) i_map (
      .op(op_code), .large_page(large_page), .bus_16(bus_16),
      .rw_cnt(rw_cnt), .er_cnt(er_cnt),
      .cmd1(f_cmd1), .addr(f_addr), .cmd2(f_cmd2), .data(f_data),
      .wdir(f_wdir), .wide(f_wide), .big(f_big), .cnt(f_cnt)
   );

   nand_opcode_pair i_pair (
      .op(op_code), .large_page(large_page), .word(f_word)
   );

   logic         pipe_vld [0:LAT];
   logic [W-1:0] pipe_dat [0:LAT];

   assign pipe_vld[0] = op_valid;
   assign pipe_dat[0] = {f_cmd1, f_addr, f_cmd2, f_data, f_wdir, f_wide,
                         f_big, f_cnt, f_word};

   for (genvar g = 0; g < LAT; g++) begin : g_stage
      nand_phase_stage #(.W(W)) i_stage (
         .clk(clk), .rst_n(rst_n),
         .in_vld(pipe_vld[g]), .in_dat(pipe_dat[g]),
         .out_vld(pipe_vld[g+1]), .out_dat(pipe_dat[g+1])
      );
   end

   assign out_valid = pipe_vld[LAT];
   assign {cmd1_en, addr_en, cmd2_en, data_en, write_dir, wide_data,
           big_page, addr_cnt, cmd_word} = pipe_dat[LAT];

   AST_CMD2_HAS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && cmd2_en |-> addr_en && cmd1_en); // R3
   AST_WRITE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && write_dir |-> data_en && cmd2_en); // R5
   AST_WIDE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && wide_data |-> data_en); // R4
   AST_NO_ADDR_NO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !addr_en |-> addr_cnt == '0 && !data_en); // R6
   AST_CMD1_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> cmd1_en); // R10
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(cmd_word) && $stable(addr_cnt) && $stable(big_page)); // R2

endmodule

// File: tb/test_nand_phase_decoder.sv
module test_nand_phase_decoder;
   import nand_phase_pkg::*;

   localparam int CW  = 3;
   localparam int LAT = 2;
   localparam int W   = 7 + CW + 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic op_valid = 1'b0;
   logic [3:0] op_code = '0;
   logic large_page = 1'b0, bus_16 = 1'b0;
   logic [CW-1:0] rw_cnt = '0, er_cnt = '0;
   logic out_valid, cmd1_en, addr_en, cmd2_en, data_en, write_dir, wide_data, big_page;
   logic [CW-1:0] addr_cnt;
   logic [15:0] cmd_word;

   always #5 clk = ~clk;

   nand_phase_decoder #(.CYC_W(CW), .LAT(LAT)) i_nand_phase_decoder (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .large_page(large_page), .bus_16(bus_16), .rw_cnt(rw_cnt), .er_cnt(er_cnt),
      .out_valid(out_valid), .cmd1_en(cmd1_en), .addr_en(addr_en),
      .cmd2_en(cmd2_en), .data_en(data_en), .write_dir(write_dir),
      .wide_data(wide_data), .big_page(big_page), .addr_cnt(addr_cnt),
      .cmd_word(cmd_word)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   typedef struct {
      int           due;
      logic [W-1:0] exp;
      string        tag;
   } item_t;
   item_t q[$];

   logic [W-1:0] got;
   logic [W-1:0] prev;
   assign got = {cmd1_en, addr_en, cmd2_en, data_en, write_dir, wide_data,
                 big_page, addr_cnt, cmd_word};

   // Reference model built from the requirements
   function automatic logic [W-1:0] model(int op, bit lp, bit b16, int rw, int er);
      bit c1 = 1, ad = 1, c2 = 0, dt = 0, wr = 0, wd = 0, bg = lp; // R9 default
      int cnt = 0;
      logic [15:0] wrd = 16'h0000;
      case (op)
         0: begin dt = 1; wd = b16; cnt = rw; wrd = lp ? 16'h3000 : 16'h0000; end // R4
         1: begin dt = 1; wd = b16; cnt = rw; wrd = lp ? 16'h3000 : 16'h0050; end // R4
         2: begin dt = 1; wd = b16; cnt = rw; wrd = lp ? 16'hE005 : 16'h0005; end // R4
         3: begin c2 = 1; dt = 1; wr = 1; wd = b16; cnt = rw; wrd = 16'h1080; end // R5
         4: begin ad = 0; wrd = 16'h0080; end                                      // R6
         5: begin c2 = 1; cnt = er; wrd = 16'hD060; end                            // R3
         6: begin bg = 0; dt = 1; cnt = 1; wrd = 16'h0090; end                     // R7
         7: begin bg = 0; ad = 0; wrd = 16'h0070; end                              // R8
         8: begin bg = 0; ad = 0; wrd = 16'h00FF; end                              // R8
         default: ;                                                                // R10
      endcase
      return {c1, ad, c2, dt, wr, wd, bg, CW'(cnt), wrd};
   endfunction

   function automatic string tag_of(int op, bit lp);
      case (op)
         0, 1, 2: return lp ? "R4/R9" : "R4";
         3:       return lp ? "R5/R9" : "R5";
         4:       return "R6";
         5:       return "R3";
         6:       return "R7";
         7, 8:    return "R8";
         default: return "R10";
      endcase
   endfunction

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (!rst_n) q.delete();
      else if (op_valid) begin
         item_t it;
         it.due = cyc + LAT - 1;
         it.exp = model(int'(op_code), large_page, bus_16, int'(rw_cnt), int'(er_cnt));
         it.tag = tag_of(int'(op_code), large_page);
         q.push_back(it);
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            checks++;
            if (q.size() == 0 || q[0].due != cyc) begin
               fails++;
               $display("FAIL R2 unexpected out_valid at cycle %0d: got 1 expected 0", cyc);
            end else begin
               if (got !== q[0].exp) begin
                  fails++;
                  $display("FAIL %s word: got %h expected %h", q[0].tag, got, q[0].exp);
               end
               void'(q.pop_front());
            end
         end else begin
            checks++;
            if (got !== prev) begin
               fails++;
               $display("FAIL R2 hold: got %h expected %h", got, prev);
            end
            if (q.size() != 0 && q[0].due == cyc) begin
               fails++;
               $display("FAIL R2 late result: got out_valid 0 expected 1");
               void'(q.pop_front());
            end
         end
      end
      prev = got;
   end

   task automatic check_reset();
      checks++;
      if (out_valid !== 1'b0 || got !== '0) begin
         fails++;
         $display("FAIL R1 reset state: got %b/%h expected 0/0", out_valid, got);
      end
   endtask

   task automatic send(int op, bit lp, bit b16, int rw, int er);
      @(negedge clk); #1;
      op_valid = 1'b1; op_code = 4'(op); large_page = lp; bus_16 = b16;
      rw_cnt = CW'(rw); er_cnt = CW'(er);
   endtask

   // Idle cycles with scrambled inputs: R2 ignore check
   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
         op_valid = 1'b0; op_code = 4'($urandom); large_page = 1'($urandom);
         bus_16 = 1'($urandom); rw_cnt = CW'($urandom); er_cnt = CW'($urandom);
      end
   endtask

   initial begin
      #2000000;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_reset();                      // R1 during reset
      #1 rst_n = 1'b1;
      idle(2);
      @(negedge clk);
      check_reset();                      // R1 after release, before requests
      for (int op = 0; op < 16; op++)
         for (int m = 0; m < 4; m++) begin
            send(op, m[1], m[0], (op + m + 2) % 8, 7 - (op % 8));
            if ((op + m) % 3 == 0) idle(1 + (op % 3));
         end
      // forced-off cases with both device options set: R7 R8
      send(6, 1, 1, 5, 2); send(7, 1, 1, 5, 2); send(8, 1, 1, 5, 2);
      idle(4);
      // back-to-back mix then reset in the middle of activity: R1
      send(5, 1, 0, 3, 6); send(3, 1, 1, 4, 1); send(2, 0, 1, 6, 3);
      idle(LAT + 2);
      #1 rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check_reset();
      #1 rst_n = 1'b1;
      send(1, 0, 0, 2, 2);
      idle(LAT + 4);
      if (q.size() != 0) begin
         checks++; fails++;
         $display("FAIL R2 pending results: got %0d expected 0", q.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule